// File: doc/BRIEF.md
# Wake-on-LAN Magic Pattern Detector

This block watches the receive byte stream of an Ethernet MAC and raises a wake signal when a frame carries the remote wake-up pattern. The pattern is a sync run of six 0xFF bytes, immediately followed by sixteen consecutive copies of the station's 48-bit individual address. The pattern may start at any byte offset in a frame. Only frames that the destination address filter accepted are scanned.

Two enables select when scanning is active. One is for normal operation, with the system bus powered up. The other is for operation with the bus powered down. In either mode a detection sets a sticky wake pin, which is mirrored on a status output. In the powered-up mode a detection also pulses an interrupt-status event for one cycle.

The wake pin stays high until software pulses the clear input, or until both enables are cleared. The receive stream is presented one byte per valid cycle. A start marker comes with the first byte of a frame, and an end marker comes with its last byte.

Top module: `wol_detector`

## Requirements
- R1: After the last byte of a complete pattern (6 × 0xFF, then 16 address copies) is accepted, `wakePin` is high on the next clock edge.
- R2: A frame whose `frameAccepted` flag is low on its start byte never causes a detection.
- R3: With `enUp` and `enDown` both low, no detection happens, and `wakePin` is cleared on the next edge.
- R4: `wakeIrq` pulses for exactly one cycle per detection, together with the rise of `wakePin`, and only while `enUp` is set. A detection made with only `enDown` set raises `wakePin` without an interrupt.
- R5: `wakeStatus` always equals `wakePin`.
- R6: `wakePin` stays high until `wakeClear` is sampled high. If a detection and `wakeClear` fall on the same edge, the detection wins.
- R7: A sync run longer than six 0xFF bytes is accepted. The six bytes just before the first address copy satisfy the sync part.
- R8: A byte that mismatches during the address copies restarts the matcher. That same byte is re-examined as a sync byte, so a 0xFF there starts a new run of length one.
- R9: Address bytes are compared most significant first: `stationAddr[47:40]` is the first byte of each copy. A byte-reversed copy does not match.
- R10: The matcher restarts at every start marker. A pattern cut by an end marker and continued in the next frame is not detected.
- R11: The pattern is detected at any byte offset in a frame. Two separate patterns in one frame give two interrupt pulses.
- R12: After reset, `wakePin`, `wakeStatus` and `wakeIrq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | A receive byte is present this cycle |
| byteData | input | 8 | Receive byte |
| frameStart | input | 1 | Qualifies the first byte of a frame |
| frameEnd | input | 1 | Qualifies the last byte of a frame |
| frameAccepted | input | 1 | Address filter passed this frame; sampled with the start byte |
| stationAddr | input | 48 | Station individual address; bits 47:40 are sent first |
| enUp | input | 1 | Enable wake detection with the bus powered up |
| enDown | input | 1 | Enable wake detection with the bus powered down |
| wakeClear | input | 1 | Software clear of the wake pin |
| wakePin | output | 1 | Sticky wake output |
| wakeStatus | output | 1 | Readable copy of the wake pin level |
| wakeIrq | output | 1 | One-cycle interrupt-status event (powered-up mode) |

## Verification
Several properties are checked on every cycle:
- the status output mirrors the pin;
- an interrupt pulse lasts one cycle, requires the powered-up enable, and coincides with the pin being high;
- the pin holds while neither the clear nor a disable is present;
- the pin rises only right after a received byte.

Whether the pin should rise at all depends on the whole byte history of a frame. That includes the filter flag, long sync runs, restarts after a mismatch, the byte order of the address, and patterns split across frames. Only the bench's frames, compared against a reference pattern search, can show that behaviour.

// File: rtl/wol_pkg.sv
package wol_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic take;       // a scanned byte is consumed this cycle
    logic frameRst;   // the consumed byte is the first of a frame
    logic flush;      // scanning disabled: drop the sync run
    logic startCopy;  // first address byte matched after sync
    logic advance;    // next address byte matched
  } wolStrobe_t;

  typedef enum logic {
    ST_SYNC = 1'b0,
    ST_ADDR = 1'b1
  } wolState_t;

endpackage

// File: rtl/wol_datapath.sv
module wol_datapath
  import wol_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              byteData,
  input  logic [ADDR_BYTES*8-1:0] stationAddr,
  input  wolStrobe_t              strb,
  output logic                    isFf,
  output logic                    syncReady,
  output logic                    eqExpected,
  output logic                    eqFirst,
  output logic                    lastByte
);

  localparam int IDX_W    = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CNT_W    = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam int RUN_W    = $clog2(SYNC_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_COPY = CNT_W'(COPIES - 1);
  localparam logic [RUN_W-1:0] RUN_FULL  = RUN_W'(SYNC_LEN);

  logic [7:0]       addrByte [ADDR_BYTES];
  logic [7:0]       expByte;
  logic [RUN_W-1:0] runFf;
  logic [IDX_W-1:0] byteIdx;
  logic [CNT_W-1:0] copyCnt;

  // Address bytes in transmission order: most significant byte first.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gAddr
    assign addrByte[g] = stationAddr[(ADDR_BYTES-1-g)*8 +: 8];
  end

  always_comb begin
    expByte = addrByte[0];
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (byteIdx == IDX_W'(i)) expByte = addrByte[i];
    end
  end

  assign isFf       = (byteData == 8'hFF);
  assign syncReady  = (runFf == RUN_FULL);
  assign eqExpected = (byteData == expByte);
  assign eqFirst    = (byteData == addrByte[0]);
  assign lastByte   = (byteIdx == LAST_IDX) && (copyCnt == LAST_COPY);

  // Saturating count of consecutive 0xFF bytes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFf <= '0;
    end else if (strb.flush) begin
      runFf <= '0;
    end else if (strb.take) begin
      if (!isFf)                              runFf <= '0;
      else if (strb.frameRst)                 runFf <= RUN_W'(1);
      else if (runFf != RUN_FULL)             runFf <= runFf + RUN_W'(1);
    end
  end

  // Position within the address copies.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      copyCnt <= '0;
    end else if (strb.startCopy) begin
      byteIdx <= (ADDR_BYTES > 1) ? IDX_W'(1) : '0;
      copyCnt <= (ADDR_BYTES > 1) ? '0 : CNT_W'(1);
    end else if (strb.advance) begin
      if (byteIdx == LAST_IDX) begin
        byteIdx <= '0;
        copyCnt <= copyCnt + CNT_W'(1);
      end else begin
        byteIdx <= byteIdx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/wol_control.sv
module wol_control
  import wol_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       frameAccepted,
  input  logic       enUp,
  input  logic       enDown,
  input  logic       wakeClear,
  input  logic       isFf,
  input  logic       syncReady,
  input  logic       eqExpected,
  input  logic       eqFirst,
  input  logic       lastByte,
  output wolStrobe_t strb,
  output logic       wakePin,
  output logic       wakeIrq
);

  wolState_t state, stEff, stNext;
  logic inFrame, acceptQ;
  logic enAny, take, ready, detect, canStart;

  assign enAny = enUp | enDown;
  assign take  = byteValid & enAny &
                 (frameStart ? frameAccepted : (inFrame & acceptQ));
  // A start byte is always judged from a clean matcher.
  assign stEff    = frameStart ? ST_SYNC : state;
  assign ready    = syncReady & ~frameStart;
  assign canStart = ~isFf & ready & eqFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      acceptQ <= 1'b0;
    end else if (byteValid && frameStart) begin
      inFrame <= ~frameEnd;
      acceptQ <= frameAccepted;
    end else if (byteValid && frameEnd) begin
      inFrame <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.take     = take;
    strb.frameRst = frameStart;
    strb.flush    = ~enAny;
    detect        = 1'b0;
    stNext        = state;
    if (!enAny) begin
      stNext = ST_SYNC;
    end else if (take) begin
      stNext = ST_SYNC;
      case (stEff)
        ST_SYNC: begin
          if (canStart) begin
            strb.startCopy = 1'b1;
            stNext         = ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (eqExpected) begin
            if (lastByte) begin
              detect = 1'b1;
            end else begin
              strb.advance = 1'b1;
              stNext       = ST_ADDR;
            end
          end else if (canStart) begin
            strb.startCopy = 1'b1;
            stNext         = ST_ADDR;
          end
        end
        default: stNext = ST_SYNC;
      endcase
      if (frameEnd) stNext = ST_SYNC;
    end else if (byteValid && (frameStart || frameEnd)) begin
      stNext = ST_SYNC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SYNC;
      wakePin <= 1'b0;
      wakeIrq <= 1'b0;
    end else begin
      state   <= stNext;
      wakeIrq <= detect & enUp;
      if (!enAny)         wakePin <= 1'b0;
      else if (detect)    wakePin <= 1'b1;
      else if (wakeClear) wakePin <= 1'b0;
    end
  end

endmodule

// File: rtl/wol_detector.sv
module wol_detector
  import wol_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  input  logic                    frameStart,
  input  logic                    frameEnd,
  input  logic                    frameAccepted,
  input  logic [ADDR_BYTES*8-1:0] stationAddr,
  input  logic                    enUp,
  input  logic                    enDown,
  input  logic                    wakeClear,
  output logic                    wakePin,
  output logic                    wakeStatus,
  output logic                    wakeIrq
);

  wolStrobe_t strb;
  logic isFf, syncReady, eqExpected, eqFirst, lastByte;

  wol_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .byteData(byteData), .stationAddr(stationAddr),
    .strb(strb), .isFf(isFf), .syncReady(syncReady), .eqExpected(eqExpected),
    .eqFirst(eqFirst), .lastByte(lastByte)
  );

  wol_control ctl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart),
    .frameEnd(frameEnd), .frameAccepted(frameAccepted), .enUp(enUp),
    .enDown(enDown), .wakeClear(wakeClear), .isFf(isFf), .syncReady(syncReady),
    .eqExpected(eqExpected), .eqFirst(eqFirst), .lastByte(lastByte),
    .strb(strb), .wakePin(wakePin), .wakeIrq(wakeIrq)
  );

  assign wakeStatus = wakePin;

endmodule

// File: rtl/wol_detector_checker.sv
module wol_detector_checker #(
  parameter int ADDR_BYTES = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    byteValid,
  input logic [7:0]              byteData,
  input logic                    frameStart,
  input logic                    frameEnd,
  input logic                    frameAccepted,
  input logic [ADDR_BYTES*8-1:0] stationAddr,
  input logic                    enUp,
  input logic                    enDown,
  input logic                    wakeClear,
  input logic                    wakePin,
  input logic                    wakeStatus,
  input logic                    wakeIrq
);

  p_status_mirror_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakeStatus == wakePin);

  p_irq_needs_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> $past(enUp));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |=> !wakeIrq);

  p_irq_with_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> wakePin);

  p_pin_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wakePin && !wakeClear && (enUp || enDown)) |=> wakePin);

  p_pin_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enUp && !enDown) |=> !wakePin);

  p_rise_on_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakePin) |-> $past(byteValid));

endmodule

bind wol_detector wol_detector_checker #(.ADDR_BYTES(ADDR_BYTES)) chk_i (.*);

// File: tb/wol_detector_tb.sv
`timescale 1ns/1ps
module wol_detector_tb_top;

  localparam int PLEN = 6 + 16 * 6;
  localparam int MAXF = 420;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic frameStart = 1'b0, frameEnd = 1'b0, frameAccepted = 1'b0;
  logic [47:0] stationAddr = 48'h02_11_22_33_44_55;
  logic enUp = 1'b0, enDown = 1'b0, wakeClear = 1'b0;
  logic wakePin, wakeStatus, wakeIrq;

  int checks = 0, errors = 0, irqCnt = 0;
  logic [7:0] frm [MAXF];

  always #4 clk = ~clk;

  wol_detector dut_i (.*);

  always @(negedge clk) if (rstN && wakeIrq) irqCnt++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] aByte(int k);
    return stationAddr[(5-k)*8 +: 8];
  endfunction

  function automatic logic [7:0] noise();
    return 8'($urandom % 255);
  endfunction

  task automatic fillNoise(int len);
    for (int i = 0; i < len; i++) frm[i] = noise();
  endtask

  task automatic putPat(int off, int copies);
    for (int i = 0; i < 6; i++) frm[off+i] = 8'hFF;
    for (int c = 0; c < copies; c++)
      for (int k = 0; k < 6; k++) frm[off+6+c*6+k] = aByte(k);
  endtask

  // Reference: non-overlapping search for complete patterns.
  function automatic int countPat(int len);
    int n = 0;
    int i = 0;
    while (i + PLEN <= len) begin
      bit ok = 1'b1;
      for (int j = 0; j < 6; j++) if (frm[i+j] != 8'hFF) ok = 1'b0;
      for (int j = 0; j < 96; j++) if (frm[i+6+j] != aByte(j % 6)) ok = 1'b0;
      if (ok) begin n++; i += PLEN; end
      else i++;
    end
    return n;
  endfunction

  task automatic sendFrame(int len, bit acc, bit clrLast, bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 5 == 0)) begin
        @(negedge clk);
        byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0; wakeClear = 1'b0;
      end
      @(negedge clk);
      byteValid = 1'b1; byteData = frm[i];
      frameStart = (i == 0); frameEnd = (i == len - 1);
      frameAccepted = acc;
      wakeClear = clrLast && (i == len - 1);
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0; wakeClear = 1'b0;
    frameAccepted = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearWake();
    @(negedge clk); wakeClear = 1'b1;
    @(negedge clk); wakeClear = 1'b0;
    @(negedge clk);
  endtask

  task automatic runCheck(string req, int len, bit acc);
    int base = irqCnt;
    int n = countPat(len);
    int expW = ((enUp || enDown) && acc && n > 0) ? 1 : 0;
    int expI = (enUp && acc) ? n : 0;
    sendFrame(len, acc, 1'b0, 1'b1);
    chk({req, " wakePin"}, int'(wakePin), expW);
    chk("R5 wakeStatus", int'(wakeStatus), int'(wakePin));
    chk({req, " irq count"}, irqCnt - base, expI);
    clearWake();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R12 reset wakePin", int'(wakePin), 0);
    chk("R12 reset wakeIrq", int'(wakeIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 after reset wakeStatus", int'(wakeStatus), 0);

    // R1 R9 R11: pattern at offset 17, powered-up mode.
    enUp = 1'b1; enDown = 1'b0;
    fillNoise(140); putPat(17, 16);
    runCheck("R1 R11 offset", 140, 1'b1);
    chk("R6 cleared by wakeClear", int'(wakePin), 0);

    // R2: filter rejected.
    fillNoise(130); putPat(5, 16);
    runCheck("R2 rejected frame", 130, 1'b0);

    // R3: both enables clear.
    enUp = 1'b0;
    fillNoise(130); putPat(5, 16);
    runCheck("R3 disabled", 130, 1'b1);

    // R4: powered-down only: pin without irq.
    enDown = 1'b1;
    fillNoise(120); putPat(10, 16);
    runCheck("R4 down mode", 120, 1'b1);

    // R7: long sync run.
    enUp = 1'b1; enDown = 1'b0;
    fillNoise(140);
    for (int i = 0; i < 9; i++) frm[3+i] = 8'hFF;
    putPat(12 - 6 + 3, 16);
    runCheck("R7 long sync", 140, 1'b1);

    // R8: mismatch 0xFF restarts a run of length one.
    fillNoise(260);
    putPat(2, 3);
    frm[2+6+18] = aByte(0); frm[2+6+19] = aByte(1);
    frm[2+6+20] = 8'hFF;
    for (int i = 1; i < 6; i++) frm[2+6+20+i] = 8'hFF;
    putPat(2+6+20, 16);
    chk("R8 model sees one pattern", countPat(260), 1);
    runCheck("R8 restart", 260, 1'b1);

    // R9: byte-reversed copies.
    fillNoise(130);
    for (int i = 0; i < 6; i++) frm[4+i] = 8'hFF;
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 6; k++) frm[10+c*6+k] = aByte(5-k);
    runCheck("R9 reversed order", 130, 1'b1);

    // 15 copies only.
    fillNoise(130); putPat(4, 15);
    runCheck("R1 fifteen copies", 130, 1'b1);

    // R10: pattern split across two frames.
    fillNoise(60); putPat(0, 8);
    sendFrame(6 + 48, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 48; i++) frm[i] = aByte(i % 6);
    sendFrame(48, 1'b1, 1'b0, 1'b0);
    chk("R10 split pattern", int'(wakePin), 0);

    // R6: clear on the detecting edge loses.
    fillNoise(PLEN + 4); putPat(4, 16);
    sendFrame(PLEN + 4, 1'b1, 1'b1, 1'b0);
    chk("R6 detect beats clear", int'(wakePin), 1);
    // R3: disabling drops the pin.
    @(negedge clk); enUp = 1'b0;
    @(negedge clk);
    chk("R3 disable clears pin", int'(wakePin), 0);
    enUp = 1'b1;

    // R11: two patterns in one frame.
    fillNoise(230); putPat(3, 16); putPat(3 + PLEN + 7, 16);
    runCheck("R11 two patterns", 230, 1'b1);

    // Random frames with a random address.
    stationAddr = {noise() & 8'hFE, noise(), noise(), noise(), noise(), noise()};
    for (int f = 0; f < 60; f++) begin
      int len = 110 + int'($urandom % 300);
      int mode = int'($urandom % 4);
      bit acc = ($urandom % 4) != 0;
      int sel = int'($urandom % 4);
      enUp = (sel != 1) && (sel != 3);
      enDown = (sel == 1) || (sel == 2);
      fillNoise(len);
      if (mode == 1) putPat(int'($urandom % (len - PLEN + 1)), 16);
      if (mode == 2) begin
        putPat(int'($urandom % (len - PLEN + 1)), 16);
        frm[$urandom % len] = noise();
      end
      if (mode == 3 && len >= 2 * PLEN) begin
        putPat(0, 16); putPat(len - PLEN, 16);
      end
      runCheck("R1 R2 R4 random", len, acc);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule